// File: doc/BRIEF.md
# Multicycle Shared-Unit Processor Datapath

This block is the datapath half of a 32-bit load/store processor that runs each instruction over several clock cycles. One word-wide memory holds both program and data, one ALU does every piece of arithmetic (PC increment, branch target, address offset and register operations), and a small set of internal holding registers carries values from one cycle to the next: the instruction register, the memory data register, two register-operand latches and an ALU result latch. A 32-entry register file sits beside them.

The block makes no sequencing decisions. An external controller drives every write strobe and multiplexer select on each cycle and reads back the current opcode and the ALU zero flag to choose its next step. The supported instruction classes are word load, word store, equality branch, absolute jump and register-register add, subtract, and, or, xor, nor and signed set-less-than. A load port lets a test environment fill or read the memory words directly. All pins are plain level signals sampled on the rising clock edge; no interface carries a valid/ready handshake, so there is no back-pressure to manage.

Top module: `mcd_core`

## Requirements
- R1: A synchronous reset clears the PC, the instruction register, the memory data register, both operand latches, the ALU result latch and all register-file entries to zero.
- R2: The memory address is the PC when `addr_sel`=0 and the ALU result latch when `addr_sel`=1; the word index is address bits [31:2] taken modulo the memory depth; memory read data is the addressed word while `mem_rd` is high and zero otherwise.
- R3: The instruction register loads the memory read data only in cycles with `ir_wr` high; the memory data register, both operand latches and the ALU result latch load on every clock edge; `opcode` shows instruction register bits [31:26].
- R4: The first ALU operand is the PC when `opa_sel`=0 and the first operand latch when `opa_sel`=1.
- R5: The second ALU operand is, for `opb_sel` 00/01/10/11: the second operand latch, the constant 4, the sign-extended instruction bits [15:0], and that value shifted left by two.
- R6: `alu_op`=00 forces add and 01 forces subtract; 10 or 11 decode instruction bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A set-less-than, any other value add.
- R7: Set-less-than returns 1 when the first operand is below the second as signed 32-bit values, else 0; `alu_zero` is high exactly when the live ALU result is zero.
- R8: The next-PC value is, for `pc_src` 00/01/1x: the live ALU result, the ALU result latch, and {PC[31:28], instruction bits [25:0], 2'b00}.
- R9: The PC takes the next-PC value at a clock edge when `pc_wr` is high, or when `pc_wr_cond` and `alu_zero` are both high; otherwise it holds.
- R10: Register reads use instruction bits [25:21] and [20:16]; the write address is bits [20:16] when `dst_sel`=0 and bits [15:11] when `dst_sel`=1; write data is the ALU result latch when `wb_sel`=0 and the memory data register when `wb_sel`=1; a write happens at the edge when `reg_wr` is high.
- R11: Register 0 always reads as zero and writes to it are discarded.
- R12: With `mem_wr` high the second operand latch is written into the word at the current memory address; a load-port write (`ld_we`) in the same cycle takes priority; `ld_rdata` shows the word at `ld_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_wr | input | 1 | Unconditional PC write strobe |
| pc_wr_cond | input | 1 | PC write strobe qualified by the zero flag |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write strobe |
| ir_wr | input | 1 | Instruction register load strobe |
| wb_sel | input | 1 | Register write data select: 0 ALU latch, 1 memory data register |
| pc_src | input | 2 | Next-PC select |
| alu_op | input | 2 | ALU operation class |
| opb_sel | input | 2 | Second ALU operand select |
| opa_sel | input | 1 | First ALU operand select |
| reg_wr | input | 1 | Register file write strobe |
| dst_sel | input | 1 | Register write address select |
| opcode | output | 6 | Instruction register bits [31:26] |
| alu_zero | output | 1 | Live ALU result equals zero |
| pc_q | output | 32 | Current program counter |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | log2(MEM_WORDS) | Load-port word index |
| ld_wdata | input | 32 | Load-port write data |
| ld_rdata | output | 32 | Word at `ld_addr` |

## Verification
The bench drives a short program through the controller-style strobe sequences and then a long run of random strobe combinations, which reach select codes no real instruction uses (`pc_src`=11, `alu_op`=11, unlisted function codes) and address wrap beyond the memory depth. A taken branch over a store, a not-taken branch and a jump catch a PC write enable that ignores the zero flag or a jump target built from the wrong PC bits: the skipped store would land in memory or the PC would miss 84. Signed set-less-than with a negative operand, a write aimed at register 0, and a store of that register catch an unsigned compare or a register 0 that keeps its data. Because the operand latches load every edge while the instruction register holds, a design that gated the wrong one would feed stale operands into the ALU and mismatch the zero flag or the PC within a cycle.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  // 4-bit ALU function codes produced by the second-level decoder
  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_XOR = 4'b0010,
    ALU_NOR = 4'b0011,
    ALU_ADD = 4'b0110,
    ALU_SUB = 4'b1110,
    ALU_SLT = 4'b1111
  } alu_fn_e;

  // operation class from the controller
  localparam logic [1:0] AOP_ADD = 2'b00;
  localparam logic [1:0] AOP_SUB = 2'b01;

  // register-register function field values
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // second operand select codes
  localparam logic [1:0] OPB_REG   = 2'b00;
  localparam logic [1:0] OPB_FOUR  = 2'b01;
  localparam logic [1:0] OPB_IMM   = 2'b10;
  localparam logic [1:0] OPB_IMMX4 = 2'b11;

  // next-PC select codes
  localparam logic [1:0] NPC_ALU  = 2'b00;
  localparam logic [1:0] NPC_LAT  = 2'b01;

endpackage

// File: rtl/mcd_alu_ctrl.sv
module mcd_alu_ctrl
  import mcd_pkg::*;
(
  input  logic [1:0] alu_op,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);

  always_comb begin
    fn = ALU_ADD;
    case (alu_op)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      default: begin
        case (funct)
          FN_ADD:  fn = ALU_ADD;
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_XOR:  fn = ALU_XOR;
          FN_NOR:  fn = ALU_NOR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  logic lt_signed;
  assign lt_signed = $signed(a) < $signed(b);

  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [$clog2(N)-1:0] ra1,
  input  logic [$clog2(N)-1:0] ra2,
  input  logic [$clog2(N)-1:0] wa,
  input  logic                 we,
  input  logic [W-1:0]         wd,
  output logic [W-1:0]         rd1,
  output logic [W-1:0]         rd2
);

  localparam int AW = $clog2(N);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '{default: '0};
    end else if (we && (wa != AW'(0))) begin
      regs[wa] <= wd;
    end
  end

  // entry 0 is hard-wired to zero on both read ports
  assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
  assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];

endmodule

// File: rtl/mcd_memory.sv
module mcd_memory #(
  parameter int W     = 32,
  parameter int WORDS = 64
) (
  input  logic                     clk,
  input  logic [W-1:0]             addr,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata,
  input  logic                     ld_we,
  input  logic [$clog2(WORDS)-1:0] ld_addr,
  input  logic [W-1:0]             ld_wdata,
  output logic [W-1:0]             ld_rdata
);

  localparam int IW = $clog2(WORDS);

  logic [W-1:0]  words [WORDS];
  logic [IW-1:0] idx;

  // byte address to word index, wrapping at the array depth
  assign idx = IW'(addr >> 2);

  always_ff @(posedge clk) begin
    if (ld_we) begin
      words[ld_addr] <= ld_wdata;
    end else if (wr_en) begin
      words[idx] <= wdata;
    end
  end

  assign rdata    = rd_en ? words[idx] : '0;
  assign ld_rdata = words[ld_addr];

endmodule

// File: rtl/mcd_core.sv
module mcd_core
  import mcd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pc_wr,
  input  logic                         pc_wr_cond,
  input  logic                         addr_sel,
  input  logic                         mem_rd,
  input  logic                         mem_wr,
  input  logic                         ir_wr,
  input  logic                         wb_sel,
  input  logic [1:0]                   pc_src,
  input  logic [1:0]                   alu_op,
  input  logic [1:0]                   opb_sel,
  input  logic                         opa_sel,
  input  logic                         reg_wr,
  input  logic                         dst_sel,
  output logic [5:0]                   opcode,
  output logic                         alu_zero,
  output logic [DATA_W-1:0]            pc_q,
  input  logic                         ld_we,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
  input  logic [DATA_W-1:0]            ld_wdata,
  output logic [DATA_W-1:0]            ld_rdata
);

  localparam int REGS   = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int REG_AW = $clog2(REGS);

  // architectural and holding registers
  logic [DATA_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] reg_a;
  logic [DATA_W-1:0] reg_b;
  logic [DATA_W-1:0] alu_out;

  // combinational datapath nets
  logic [DATA_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_x4;
  logic [DATA_W-1:0] jmp_tgt;
  logic [DATA_W-1:0] next_pc;
  logic [DATA_W-1:0] rf_rd1;
  logic [DATA_W-1:0] rf_rd2;
  logic [DATA_W-1:0] rf_wd;
  logic [REG_AW-1:0] rf_wa;
  logic              pc_en;
  alu_fn_e           fn;

  // instruction field extraction
  assign imm_sext = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign imm_x4   = {imm_sext[DATA_W-3:0], 2'b00};
  assign jmp_tgt  = {pc[DATA_W-1:DATA_W-4], ir[TGT_W-1:0], 2'b00};
  assign opcode   = ir[31:26];

  // shared memory port
  assign mem_addr = addr_sel ? alu_out : pc;

  mcd_memory #(
    .W     (DATA_W),
    .WORDS (MEM_WORDS)
  ) u_mem (
    .clk      (clk),
    .addr     (mem_addr),
    .rd_en    (mem_rd),
    .wr_en    (mem_wr),
    .wdata    (reg_b),
    .rdata    (mem_rdata),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_wdata (ld_wdata),
    .ld_rdata (ld_rdata)
  );

  // register file
  assign rf_wa = dst_sel ? ir[15:11] : ir[20:16];
  assign rf_wd = wb_sel ? mdr : alu_out;

  mcd_regfile #(
    .W (DATA_W),
    .N (REGS)
  ) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (ir[25:21]),
    .ra2 (ir[20:16]),
    .wa  (rf_wa),
    .we  (reg_wr),
    .wd  (rf_wd),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2)
  );

  // ALU operand selection
  assign opa = opa_sel ? reg_a : pc;

  always_comb begin
    case (opb_sel)
      OPB_REG:   opb = reg_b;
      OPB_FOUR:  opb = DATA_W'(4);
      OPB_IMM:   opb = imm_sext;
      OPB_IMMX4: opb = imm_x4;
      default:   opb = reg_b;
    endcase
  end

  mcd_alu_ctrl u_actl (
    .alu_op (alu_op),
    .funct  (ir[5:0]),
    .fn     (fn)
  );

  mcd_alu #(
    .W (DATA_W)
  ) u_alu (
    .a    (opa),
    .b    (opb),
    .fn   (fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // next PC and its write enable
  always_comb begin
    case (pc_src)
      NPC_ALU: next_pc = alu_y;
      NPC_LAT: next_pc = alu_out;
      default: next_pc = jmp_tgt;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (pc_en) begin
      pc <= next_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir <= '0;
    end else if (ir_wr) begin
      ir <= mem_rdata;
    end
  end

  // unqualified holding registers: valid only into the following cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      mdr     <= '0;
      reg_a   <= '0;
      reg_b   <= '0;
      alu_out <= '0;
    end else begin
      mdr     <= mem_rdata;
      reg_a   <= rf_rd1;
      reg_b   <= rf_rd2;
      alu_out <= alu_y;
    end
  end

  assign pc_q = pc;

endmodule

// File: rtl/mcd_core_chk.sv
module mcd_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pc_wr,
  input logic              pc_wr_cond,
  input logic              ir_wr,
  input logic              alu_zero,
  input logic [1:0]        alu_op,
  input logic [DATA_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] next_pc,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] alu_y,
  input logic [DATA_W-1:0] rf_rd1,
  input logic [DATA_W-1:0] rf_rd2
);

  assert_pc_reset_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_q));

  assert_pc_load_R9: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> (pc_q == $past(next_pc)));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(ir));

  assert_reg0_port1_R11: assert property (@(posedge clk) disable iff (rst)
    (ir[25:21] == 5'd0) |-> (rf_rd1 == '0));

  assert_reg0_port2_R11: assert property (@(posedge clk) disable iff (rst)
    (ir[20:16] == 5'd0) |-> (rf_rd2 == '0));

  assert_forced_add_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b00) |-> (alu_y == opa + opb));

  assert_forced_sub_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b01) |-> (alu_y == opa - opb));

endmodule

bind mcd_core mcd_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .ir_wr      (ir_wr),
  .alu_zero   (alu_zero),
  .alu_op     (alu_op),
  .pc_q       (pc_q),
  .ir         (ir),
  .next_pc    (next_pc),
  .opa        (opa),
  .opb        (opb),
  .alu_y      (alu_y),
  .rf_rd1     (rf_rd1),
  .rf_rd2     (rf_rd2)
);

// File: tb/mcd_core_tb.sv
module mcd_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEMW       = 64;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_wr = 0, pc_wr_cond = 0, addr_sel = 0, mem_rd = 0, mem_wr = 0;
  logic        ir_wr = 0, wb_sel = 0, opa_sel = 0, reg_wr = 0, dst_sel = 0;
  logic [1:0]  pc_src = 0, alu_op = 0, opb_sel = 0;
  logic        ld_we = 0;
  logic [5:0]  ld_addr = 0;
  logic [31:0] ld_wdata = 0;
  logic [5:0]  opcode;
  logic        alu_zero;
  logic [31:0] pc_q;
  logic [31:0] ld_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_mem [MEMW];
  logic [31:0] m_rf  [32];
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_core u_dut (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .wb_sel(wb_sel), .pc_src(pc_src), .alu_op(alu_op), .opb_sel(opb_sel),
    .opa_sel(opa_sel), .reg_wr(reg_wr), .dst_sel(dst_sel), .opcode(opcode),
    .alu_zero(alu_zero), .pc_q(pc_q), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  function automatic logic [31:0] ref_alu(input logic [1:0] op, input logic [5:0] f,
                                          input logic [31:0] x, input logic [31:0] y);
    if (op == 2'b00) return x + y;
    if (op == 2'b01) return x - y;
    case (f)
      6'h22:   return x - y;
      6'h24:   return x & y;
      6'h25:   return x | y;
      6'h26:   return x ^ y;
      6'h27:   return ~(x | y);
      6'h2A:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return x + y;
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] f);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
    return {op, t};
  endfunction

  function automatic logic [31:0] prog_word(input int i);
    case (i)
      0:  return enc_i(6'd35, 0, 1, 16'd128);
      1:  return enc_i(6'd35, 0, 2, 16'd132);
      2:  return enc_r(1, 2, 3, 6'h20);
      3:  return enc_r(1, 2, 4, 6'h22);
      4:  return enc_r(1, 2, 5, 6'h24);
      5:  return enc_r(1, 2, 6, 6'h25);
      6:  return enc_r(1, 2, 7, 6'h26);
      7:  return enc_r(1, 2, 8, 6'h27);
      8:  return enc_r(2, 1, 9, 6'h2A);
      9:  return enc_r(1, 2, 10, 6'h2A);
      10: return enc_r(1, 1, 0, 6'h20);
      11: return enc_i(6'd43, 0, 0, 16'd136);
      12: return enc_i(6'd43, 0, 4, 16'd140);
      13: return enc_i(6'd4, 3, 0, 16'd1);
      15: return enc_i(6'd4, 1, 2, 16'd5);
      16: return enc_j(6'd2, 26'd20);
      14, 17, 18, 19: return enc_i(6'd43, 0, 1, 16'd144);
      20: return enc_i(6'd43, 0, 9, 16'd148);
      21: return enc_j(6'd2, 26'd21);
      32: return 32'd7;
      33: return 32'hFFFF_FFF9;
      default: return 32'd0;
    endcase
  endfunction

  task automatic setc(input logic pcw, input logic pcwc, input logic iord, input logic mrd,
                      input logic mwr, input logic irw, input logic m2r, input logic [1:0] pcs,
                      input logic [1:0] aop, input logic [1:0] srcb, input logic srca,
                      input logic rw, input logic rdst);
    pc_wr = pcw; pc_wr_cond = pcwc; addr_sel = iord; mem_rd = mrd; mem_wr = mwr;
    ir_wr = irw; wb_sel = m2r; pc_src = pcs; alu_op = aop; opb_sel = srcb;
    opa_sel = srca; reg_wr = rw; dst_sel = rdst;
  endtask

  // one clock of the reference model, compared against the design
  task automatic tick();
    logic [31:0] ma, mrd, oa, ob, sx, y, npc, wd;
    logic [31:0] o_ir, o_mdr, o_out, o_b;
    logic [4:0]  wa;
    logic        z;
    int          mi;
    #1;
    ma  = addr_sel ? m_out : m_pc;
    mi  = int'((ma >> 2) % MEMW);
    mrd = mem_rd ? m_mem[mi] : 32'd0;
    sx  = {{16{m_ir[15]}}, m_ir[15:0]};
    oa  = opa_sel ? m_a : m_pc;
    case (opb_sel)
      2'b00: ob = m_b;
      2'b01: ob = 32'd4;
      2'b10: ob = sx;
      default: ob = sx << 2;
    endcase
    y = ref_alu(alu_op, m_ir[5:0], oa, ob);
    z = (y == 32'd0);
    check("R4 R5 R6 R7 zero flag", {31'd0, alu_zero}, {31'd0, z});
    case (pc_src)
      2'b00: npc = y;
      2'b01: npc = m_out;
      default: npc = {m_pc[31:28], m_ir[25:0], 2'b00};
    endcase
    o_ir = m_ir; o_mdr = m_mdr; o_out = m_out; o_b = m_b;
    wa = dst_sel ? o_ir[15:11] : o_ir[20:16];
    wd = wb_sel ? o_mdr : o_out;
    if (pc_wr || (pc_wr_cond && z)) m_pc = npc;
    if (ir_wr) m_ir = mrd;
    m_mdr = mrd;
    m_a   = m_rf[o_ir[25:21]];
    m_b   = m_rf[o_ir[20:16]];
    m_out = y;
    if (reg_wr && wa != 5'd0) m_rf[wa] = wd;
    if (ld_we) m_mem[ld_addr] = ld_wdata;
    else if (mem_wr) m_mem[mi] = o_b;
    @(posedge clk);
    @(negedge clk);
    check("R8 R9 program counter", pc_q, m_pc);
    check("R3 opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
    check("R2 R10 R12 memory word", ld_rdata, m_mem[ld_addr]);
  endtask

  task automatic idle();
    setc(0,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0);
    ld_we = 0;
  endtask

  task automatic run_instr();
    setc(1,0,0,1,0,1,0,2'b00,2'b00,2'b01,0,0,0); tick();   // fetch, PC+4
    setc(0,0,0,0,0,0,0,2'b00,2'b00,2'b11,0,0,0); tick();   // decode, branch target
    case (m_ir[31:26])
      6'd0: begin
        setc(0,0,0,0,0,0,0,2'b00,2'b10,2'b00,1,0,0); tick();
        setc(0,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,1,1); tick();
      end
      6'd35: begin
        setc(0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1,0,0); tick();
        setc(0,0,1,1,0,0,0,2'b00,2'b00,2'b00,0,0,0); tick();
        setc(0,0,0,0,0,0,1,2'b00,2'b00,2'b00,0,1,0); tick();
      end
      6'd43: begin
        setc(0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1,0,0); tick();
        setc(0,0,1,0,1,0,0,2'b00,2'b00,2'b00,0,0,0); tick();
      end
      6'd4: begin
        setc(0,1,0,0,0,0,0,2'b01,2'b01,2'b00,1,0,0); tick();
      end
      6'd2: begin
        setc(1,0,0,0,0,0,0,2'b10,2'b00,2'b00,0,0,0); tick();
      end
      default: idle();
    endcase
    idle();
  endtask

  task automatic peek(input int idx, input logic [31:0] exp, input string tag);
    idle();
    ld_addr = 6'(idx);
    tick();
    check(tag, ld_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < MEMW; i++) m_mem[i] = '0;
    m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_out = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 PC after reset", pc_q, 32'd0);
    check("R1 opcode after reset", {26'd0, opcode}, 32'd0);

    // load program and data
    for (int i = 0; i < MEMW; i++) begin
      idle();
      ld_we = 1; ld_addr = 6'(i); ld_wdata = prog_word(i);
      tick();
    end
    idle();

    for (int n = 0; n < 20; n++) run_instr();

    check("R8 jump target PC", pc_q, 32'd84);
    peek(34, 32'd0,  "R11 store of register 0 after write to it");
    peek(35, 32'd14, "R6 R10 subtract result stored");
    peek(36, 32'd0,  "R9 taken branch skipped store");
    peek(37, 32'd1,  "R7 signed set-less-than with negative operand");

    // random strobe phase over fresh memory contents
    for (int i = 0; i < MEMW; i++) begin
      idle();
      ld_we = 1; ld_addr = 6'(i); ld_wdata = $urandom;
      tick();
    end
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      setc(r[0] & r[20], r[1], r[2], r[3], r[4], r[5], r[6], r[8:7], r[10:9],
           r[12:11], r[13], r[14], r[15]);
      ld_we    = (r[19:17] == 3'b000);
      ld_addr  = 6'($urandom);
      ld_wdata = $urandom;
      tick();
    end

    finish_run();
  end

endmodule